// File: doc/BRIEF.md
# I2C bus recovery sequencer

This block frees an I2C bus that a target has left hung, typically with SDA held low after a transfer was cut short. A start pulse makes it take the SCL and SDA pins away from the main controller and drive them itself. With both lines released, it samples them. If both already read high, it finishes at once with success and toggles nothing. Otherwise it clocks SCL a fixed number of times, so that a stuck target can shift out the rest of its byte and let go of SDA.

After the pulses it watches both lines, still released, until both read high or a timeout window runs out. It then hands the pins back to the controller and gives a one-cycle completion pulse. On timeout it raises a bus-busy error and reports the last line values it sampled. All intervals are counted in microseconds, from a tick derived from the clock frequency parameter. The block only ever pulls SCL low and never drives SDA. The raw line inputs pass through a two-flop synchronizer.

Top module: `i2c_unhang_seq`

## Requirements
- R1: After reset, pin_own_o, scl_oe_o, sda_oe_o, done_o, err_busy_o, last_scl_o and last_sda_o are all 0.
- R2: A start_i seen in idle is accepted at that clock edge. The sequencer releases both lines and takes its decision on the second edge after acceptance. If both synchronized lines are high then, done_o is 1 in the cycle after that edge, err_busy_o is 0, and no SCL pulse is made.
- R3: Otherwise exactly NUM_PULSES SCL pulses follow. In each, scl_oe_o is 1 for PULSE_US microseconds and then 0 for PULSE_US microseconds, where one microsecond is CLK_FREQ_HZ/1e6 clock cycles.
- R4: After the last released phase the sequencer polls. On the first edge at which both synchronized lines are high it completes with done_o for exactly one cycle and err_busy_o 0.
- R5: If both lines are not high within TIMEOUT_US microseconds of polling, the sequencer completes with err_busy_o 1. last_sda_o and last_scl_o then hold the synchronized values sampled at that edge. On any completion these two outputs take the sampled values, which are 1 and 1 on success.
- R6: pin_own_o is 1 from the edge that accepts start_i until the completion edge, and it falls in the same cycle that done_o rises. scl_oe_o is 1 only while pin_own_o is 1.
- R7: sda_oe_o is 0 at all times.
- R8: start_i is ignored while pin_own_o is 1: the running sequence keeps its timing.
- R9: A change on scl_i or sda_i reaches the decision logic through two flops. A line that goes high before clock edge k is acted on at edge k+2.
- R10: err_busy_o holds its value after completion until the next accepted start_i, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to run recovery |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| pin_own_o | output | 1 | 1: pins under sequencer control, 0: under main controller |
| scl_oe_o | output | 1 | Open-drain enable for SCL, 1 pulls low |
| sda_oe_o | output | 1 | Open-drain enable for SDA, always 0 |
| done_o | output | 1 | One-cycle completion pulse |
| err_busy_o | output | 1 | Bus still busy at timeout |
| last_scl_o | output | 1 | SCL value sampled at completion |
| last_sda_o | output | 1 | SDA value sampled at completion |

## Verification
The bench builds the block with CLK_FREQ_HZ = 2 MHz, PULSE_US = 2 and TIMEOUT_US = 30. Each SCL phase is then four cycles and the polling window is sixty cycles. At that scale the nine-pulse train, the whole timeout path and a release part-way through polling all fit in a few hundred cycles, so each can be compared cycle by cycle against the behavioural model. The divider still runs with two cycles per microsecond, so the tick logic is exercised rather than bypassed.

// File: rtl/i2c_unhang_pkg.sv
package i2c_unhang_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_LOW,
    ST_HIGH,
    ST_POLL
  } rec_state_e;
endpackage

// File: rtl/i2c_unhang_sync.sv
module i2c_unhang_sync #(
  parameter int              WIDTH  = 2,
  parameter int              STAGES = 2,
  parameter logic [WIDTH-1:0] INIT  = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{INIT[b]}};
      else         chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/i2c_unhang_timer.sv
module i2c_unhang_timer #(
  parameter int CYC_PER_US = 50,
  parameter int US_W       = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [US_W-1:0] limit_i,
  output logic            expire_o
);
  localparam int PRE_W = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;

  logic tick;

  if (CYC_PER_US > 1) begin : g_pre
    logic [PRE_W-1:0] pre_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              pre_q <= '0;
      else if (load_i || tick)  pre_q <= '0;
      else                      pre_q <= pre_q + 1'b1;
    end
    assign tick = (pre_q == PRE_W'(CYC_PER_US - 1));
  end else begin : g_nopre
    assign tick = 1'b1;
  end

  logic [US_W-1:0] us_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 us_q <= '0;
    else if (load_i)             us_q <= '0;
    else if (tick && !expire_o)  us_q <= us_q + 1'b1;
  end

  assign expire_o = tick && (us_q == limit_i - 1'b1);
endmodule

// File: rtl/i2c_unhang_fsm.sv
module i2c_unhang_fsm
  import i2c_unhang_pkg::*;
#(
  parameter int NUM_PULSES = 9,
  parameter int SETTLE_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic sda_s_i,
  input  logic scl_s_i,
  input  logic expire_i,
  output logic load_o,
  output logic poll_o,
  output logic own_o,
  output logic scl_oe_o,
  output logic done_o,
  output logic err_busy_o,
  output logic last_sda_o,
  output logic last_scl_o
);
  localparam int PC_W = $clog2(NUM_PULSES + 1);
  localparam int SC_W = $clog2(SETTLE_CYC + 1);

  rec_state_e      state_q, state_d;
  logic [PC_W-1:0] pulse_q;
  logic [SC_W-1:0] settle_q;
  logic            bus_free, fin, fin_err;
  logic            own_q, oe_q, done_q, err_q, lsda_q, lscl_q;

  assign bus_free = sda_s_i & scl_s_i;

  always_comb begin
    state_d = state_q;
    fin     = 1'b0;
    fin_err = 1'b0;
    unique case (state_q)
      ST_IDLE:   if (start_i) state_d = ST_SETTLE;
      ST_SETTLE: if (settle_q == SC_W'(SETTLE_CYC - 1)) begin
                   if (bus_free) fin = 1'b1;
                   else          state_d = ST_LOW;
                 end
      ST_LOW:    if (expire_i) state_d = ST_HIGH;
      ST_HIGH:   if (expire_i)
                   state_d = (pulse_q == PC_W'(NUM_PULSES - 1)) ? ST_POLL : ST_LOW;
      ST_POLL:   if (bus_free) fin = 1'b1;
                 else if (expire_i) begin
                   fin     = 1'b1;
                   fin_err = 1'b1;
                 end
      default:   state_d = ST_IDLE;
    endcase
    if (fin) state_d = ST_IDLE;
  end

  assign load_o = (state_d != state_q);
  assign poll_o = (state_q == ST_POLL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      pulse_q  <= '0;
      settle_q <= '0;
      own_q    <= 1'b0;
      oe_q     <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      lsda_q   <= 1'b0;
      lscl_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      own_q   <= (state_d != ST_IDLE);
      oe_q    <= (state_d == ST_LOW);
      done_q  <= fin;
      if (state_q == ST_IDLE)        settle_q <= '0;
      else if (state_q == ST_SETTLE) settle_q <= settle_q + 1'b1;
      if (state_q == ST_SETTLE)                 pulse_q <= '0;
      else if (state_q == ST_HIGH && expire_i)  pulse_q <= pulse_q + 1'b1;
      if (state_q == ST_IDLE && start_i) err_q <= 1'b0;
      if (fin) begin
        err_q  <= fin_err;
        lsda_q <= sda_s_i;
        lscl_q <= scl_s_i;
      end
    end
  end

  assign own_o      = own_q;
  assign scl_oe_o   = oe_q;
  assign done_o     = done_q;
  assign err_busy_o = err_q;
  assign last_sda_o = lsda_q;
  assign last_scl_o = lscl_q;
endmodule

// File: rtl/i2c_unhang_seq.sv
module i2c_unhang_seq #(
  parameter int CLK_FREQ_HZ = 50_000_000,
  parameter int PULSE_US    = 50,
  parameter int TIMEOUT_US  = 200_000,
  parameter int NUM_PULSES  = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic pin_own_o,
  output logic scl_oe_o,
  output logic sda_oe_o,
  output logic done_o,
  output logic err_busy_o,
  output logic last_scl_o,
  output logic last_sda_o
);
  localparam int CYC_PER_US = CLK_FREQ_HZ / 1_000_000;
  localparam int MAX_US     = (TIMEOUT_US > PULSE_US) ? TIMEOUT_US : PULSE_US;
  localparam int US_W       = $clog2(MAX_US + 1);

  logic [1:0]      line_s;
  logic            load, poll, expire;
  logic [US_W-1:0] limit;

  i2c_unhang_sync #(
    .WIDTH (2),
    .STAGES(SYNC_STAGES),
    .INIT  (2'b11)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (line_s)
  );

  assign limit = poll ? US_W'(TIMEOUT_US) : US_W'(PULSE_US);

  i2c_unhang_timer #(
    .CYC_PER_US(CYC_PER_US),
    .US_W      (US_W)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .limit_i (limit),
    .expire_o(expire)
  );

  i2c_unhang_fsm #(
    .NUM_PULSES(NUM_PULSES),
    .SETTLE_CYC(SYNC_STAGES)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .sda_s_i   (line_s[0]),
    .scl_s_i   (line_s[1]),
    .expire_i  (expire),
    .load_o    (load),
    .poll_o    (poll),
    .own_o     (pin_own_o),
    .scl_oe_o  (scl_oe_o),
    .done_o    (done_o),
    .err_busy_o(err_busy_o),
    .last_sda_o(last_sda_o),
    .last_scl_o(last_scl_o)
  );

  // open drain: SDA is only ever observed
  assign sda_oe_o = 1'b0;
endmodule

// File: rtl/i2c_unhang_chk.sv
module i2c_unhang_chk #(
  parameter int PULSE_CYC  = 2500,
  parameter int NUM_PULSES = 9
) (
  input logic clk_i,
  input logic rst_ni,
  input logic pin_own_o,
  input logic scl_oe_o,
  input logic done_o,
  input logic err_busy_o
);
  int   low_run;
  int   pulse_cnt;
  logic oe_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_run   <= 0;
      pulse_cnt <= 0;
      oe_d      <= 1'b0;
    end else begin
      oe_d    <= scl_oe_o;
      low_run <= scl_oe_o ? low_run + 1 : 0;
      if (!pin_own_o)             pulse_cnt <= 0;
      else if (scl_oe_o && !oe_d) pulse_cnt <= pulse_cnt + 1;
    end
  end

  p_oe_owned_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_oe_o |-> pin_own_o);

  p_done_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !pin_own_o);

  p_own_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pin_own_o) |-> done_o);

  p_done_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_low_width_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(scl_oe_o) |-> (low_run == PULSE_CYC));

  p_pulse_limit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_cnt <= NUM_PULSES);

  p_err_at_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_busy_o) |-> done_o);
endmodule

bind i2c_unhang_seq i2c_unhang_chk #(
  .PULSE_CYC (PULSE_US * (CLK_FREQ_HZ / 1_000_000)),
  .NUM_PULSES(NUM_PULSES)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pin_own_o (pin_own_o),
  .scl_oe_o  (scl_oe_o),
  .done_o    (done_o),
  .err_busy_o(err_busy_o)
);

// File: tb/sim_i2c_unhang_seq.sv
module sim_i2c_unhang_seq;
  localparam int CLK_HZ = 2_000_000;
  localparam int P_US   = 2;
  localparam int T_US   = 30;
  localparam int NP     = 9;
  localparam int CPU    = CLK_HZ / 1_000_000;
  localparam int PH     = P_US * CPU;
  localparam int TO     = T_US * CPU;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic scl_ext = 1'b1, sda_stuck = 1'b0;
  int   rel_n = 0, base = 0, falls = 0;
  int   n_chk = 0, n_err = 0, cyc = 0;

  logic own, scl_oe, sda_oe, done, err, lscl, lsda;

  always #10 clk = ~clk;

  wire scl_line = scl_oe ? 1'b0 : scl_ext;
  wire sda_line = sda_oe ? 1'b0 : !(sda_stuck && ((falls - base) < rel_n));

  always @(posedge scl_oe) falls = falls + 1;

  i2c_unhang_seq #(
    .CLK_FREQ_HZ(CLK_HZ), .PULSE_US(P_US), .TIMEOUT_US(T_US), .NUM_PULSES(NP)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .scl_i(scl_line), .sda_i(sda_line),
    .pin_own_o(own), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .done_o(done),
    .err_busy_o(err), .last_scl_o(lscl), .last_sda_o(lsda)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_st, m_cnt, m_np;
  bit m_own, m_oe, m_done, m_err, m_ls, m_lc, s_sda, s_scl;
  bit h_sda[$], h_scl[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_np = 0;
      m_own = 0; m_oe = 0; m_done = 0; m_err = 0; m_ls = 0; m_lc = 0;
      h_sda = '{1'b1, 1'b1};
      h_scl = '{1'b1, 1'b1};
    end else begin
      s_sda = h_sda.pop_front();
      s_scl = h_scl.pop_front();
      h_sda.push_back(sda_line);
      h_scl.push_back(scl_line);
      m_done = 0;
      case (m_st)
        0: if (start) begin m_st = 1; m_cnt = 2; m_err = 0; end
        1: if (m_cnt == 1) begin
             if (s_sda && s_scl) begin m_st = 0; m_done = 1; m_err = 0; m_ls = s_sda; m_lc = s_scl; end
             else begin m_st = 2; m_cnt = PH; m_np = 0; end
           end else m_cnt--;
        2: if (m_cnt == 1) begin m_st = 3; m_cnt = PH; end else m_cnt--;
        3: if (m_cnt == 1) begin
             m_np++;
             if (m_np == NP) begin m_st = 4; m_cnt = TO; end
             else begin m_st = 2; m_cnt = PH; end
           end else m_cnt--;
        4: if (s_sda && s_scl) begin m_st = 0; m_done = 1; m_err = 0; m_ls = s_sda; m_lc = s_scl; end
           else if (m_cnt == 1) begin m_st = 0; m_done = 1; m_err = 1; m_ls = s_sda; m_lc = s_scl; end
           else m_cnt--;
        default: m_st = 0;
      endcase
      m_own = (m_st != 0);
      m_oe  = (m_st == 2);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(own == m_own,     "R6 own model",      own,    m_own);
      chk(scl_oe == m_oe,   "R3 scl_oe model",   scl_oe, m_oe);
      chk(sda_oe == 1'b0,   "R7 sda_oe",         sda_oe, 0);
      chk(done == m_done,   "R4/R9 done model",  done,   m_done);
      chk(err == m_err,     "R5/R10 err model",  err,    m_err);
      chk(lsda == m_ls,     "R5 last_sda model", lsda,   m_ls);
      chk(lscl == m_lc,     "R5 last_scl model", lscl,   m_lc);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic kick();
    @(negedge clk); start = 1'b1; base = falls;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!done && n < 5000);
  endtask

  int n;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!own && !scl_oe && !sda_oe && !done && !err && !lscl && !lsda, "R1 reset state",
        {own, scl_oe, sda_oe, done, err, lscl, lsda}, 0);

    // idle bus: immediate success
    kick(); wait_done(n);
    chk(n == 2, "R2 idle latency", n, 2);
    chk(err == 0, "R2 idle no error", err, 0);
    chk(falls - base == 0, "R2 no pulses", falls - base, 0);
    chk(lsda && lscl, "R5 last on success", {lsda, lscl}, 3);

    // SDA stuck, freed by the fourth clock
    sda_stuck = 1'b1; rel_n = 4;
    kick(); wait_done(n);
    chk(n == 3 + 18*PH, "R4 success after pulses", n, 3 + 18*PH);
    chk(falls - base == NP, "R3 pulse count", falls - base, NP);
    chk(err == 0, "R4 no error", err, 0);
    sda_stuck = 1'b0;

    // SDA stuck forever, spurious start mid-run
    sda_stuck = 1'b1; rel_n = 1000;
    kick();
    repeat (20) @(negedge clk);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_done(n);
    chk(21 + n == 2 + 18*PH + TO, "R8 timing kept", 21 + n, 2 + 18*PH + TO);
    chk(err == 1, "R5 timeout error", err, 1);
    chk(lsda == 0 && lscl == 1, "R5 last lines", {lsda, lscl}, 1);
    chk(falls - base == NP, "R3 pulse count timeout", falls - base, NP);
    repeat (5) @(negedge clk);
    chk(err == 1, "R10 error held", err, 1);
    sda_stuck = 1'b0;

    // SCL held low externally
    scl_ext = 1'b0;
    kick(); wait_done(n);
    chk(err == 1 && lscl == 0 && lsda == 1, "R5 scl stuck", {err, lscl, lsda}, 5);
    scl_ext = 1'b1;
    repeat (3) @(negedge clk);

    // new start clears error
    kick();
    chk(err == 0, "R10 cleared on start", err, 1'b0);
    wait_done(n);
    chk(n == 2 && err == 0, "R2 success after clear", n, 2);

    // release during polling
    sda_stuck = 1'b1; rel_n = 1000;
    kick();
    repeat (80) @(negedge clk);
    chk(own == 1, "R6 owned while polling", own, 1);
    sda_stuck = 1'b0;
    wait_done(n);
    chk(n == 3, "R9 release latency", n, 3);
    chk(err == 0 && own == 0, "R4 success in poll", {err, own}, 0);

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule